// File: doc/BRIEF.md
# Processor Start-Up Hold and Image Load Controller

This block governs how a soft processor comes out of reset. The processor is kept frozen after reset so that a debug channel can load a fresh program image into memory before anything executes. While the processor is frozen, the debug side can write memory words and can also set the address at which execution will begin. A separate start pulse ends the freeze. The processor's program counter is then loaded from that boot address, and from that point on the debug side can no longer write memory.

The block also controls who drives the serial transmit line. After reset the processor owns it. Once the debug receiver reports a validated frame, ownership moves to the debug logic so that control frames can be exchanged, and it stays there until the next reset. The serial serializer and the processor core are outside this block.

Top module: `boot_hold_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it is released, `cpu_hold` is 1, `tx_sel_dbg` is 0 (processor drives TX), `mem_we`, `wr_reject` and `pc_load` are 0, and `pc_value` equals the parameter `BOOT_RESET`.
- R2: A cycle with `dbg_frame_ok` high sets `tx_sel_dbg` to 1 from the next clock edge, in any state.
- R3: Once `tx_sel_dbg` is 1 it stays 1 until reset, whatever start pulses, frames or writes follow.
- R4: A debug write (`dbg_wr_en` high) in a cycle where the processor is held gives, one edge later, a single-cycle `mem_we`=1 with `mem_addr`/`mem_wdata` equal to the request.
- R5: A debug write in a cycle where the processor runs gives, one edge later, a single-cycle `wr_reject`=1 and `mem_we`=0, one strobe per request.
- R6: A `start` pulse while held drops `cpu_hold` to 0 at the next edge and raises `pc_load` for exactly that one cycle, with `pc_value` showing the boot address.
- R7: A `start` pulse while running is ignored: `cpu_hold` stays 0 and `pc_load` stays 0.
- R8: A boot-address write (`dbg_boot_we`) while held makes `pc_value` equal `dbg_boot_addr` from the next edge; while running it leaves `pc_value` unchanged. A boot write in the same cycle as `start` is accepted and is what `pc_load` carries.
- R9: Release works with or without a prior debug frame; the processor stays running until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbg_frame_ok | input | 1 | Strobe: debug receiver validated a frame |
| start | input | 1 | Strobe: release the processor |
| dbg_wr_en | input | 1 | Debug memory write request |
| dbg_wr_addr | input | ADDR_W | Debug write word address |
| dbg_wr_data | input | DATA_W | Debug write data |
| dbg_boot_we | input | 1 | Debug write of the boot address |
| dbg_boot_addr | input | ADDR_W | New boot address |
| cpu_hold | output | 1 | 1 freezes the processor |
| tx_sel_dbg | output | 1 | 1 routes TX from debug logic, 0 from processor |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Memory write address |
| mem_wdata | output | DATA_W | Memory write data |
| wr_reject | output | 1 | Pulse per refused debug write |
| pc_load | output | 1 | One-cycle pulse: load PC at release |
| pc_value | output | ADDR_W | Boot address for the PC |

## Verification
The assertions watch, on every cycle, that TX ownership never returns to the processor without reset, that a frame always moves it, that each debug write turns into exactly one write or one reject depending on hold, and that running never goes back to held and always begins with a PC load. The bench's scenarios alone show the boot-address value that reaches the PC, the ignored boot write while running, the write and start in the same cycle, and that reset mid-run restores every default.

// File: rtl/boot_pkg.sv
package boot_pkg;

  typedef enum logic [1:0] {
    ST_RESET_HOLD = 2'd0,
    ST_DEBUG_HOLD = 2'd1,
    ST_RUN        = 2'd2
  } boot_state_e;

  // Next hold/run state from the current state and the two strobes.
  function automatic boot_state_e next_state(input boot_state_e cur,
                                             input logic frame_ok,
                                             input logic start);
    boot_state_e nxt;
    nxt = cur;
    case (cur)
      ST_RESET_HOLD: begin
        if (start)         nxt = ST_RUN;
        else if (frame_ok) nxt = ST_DEBUG_HOLD;
      end
      ST_DEBUG_HOLD: if (start) nxt = ST_RUN;
      ST_RUN:        nxt = ST_RUN;
      default:       nxt = ST_RESET_HOLD;
    endcase
    return nxt;
  endfunction

  function automatic logic is_held(input boot_state_e s);
    return s != ST_RUN;
  endfunction

endpackage

// File: rtl/boot_mode_fsm.sv
module boot_mode_fsm
  import boot_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic frame_ok,
  input  logic start,
  output logic held,
  output logic release_evt,
  output logic pc_load_q
);

  boot_state_e state_q;

  assign held        = is_held(state_q);
  assign release_evt = held & start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_RESET_HOLD;
      pc_load_q <= 1'b0;
    end else begin
      state_q   <= next_state(state_q, frame_ok, start);
      pc_load_q <= release_evt;
    end
  end

endmodule

// File: rtl/tx_owner_latch.sv
module tx_owner_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic frame_ok,
  output logic sel_dbg
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sel_dbg <= 1'b0;
    else if (frame_ok) sel_dbg <= 1'b1;
  end

endmodule

// File: rtl/image_write_gate.sv
module image_write_gate #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              held,
  input  logic              req,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic              accept_evt,
  output logic              refuse_evt,
  output logic              we_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] data_q,
  output logic              reject_q
);

  assign accept_evt = req & held;
  assign refuse_evt = req & ~held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q     <= 1'b0;
      reject_q <= 1'b0;
      addr_q   <= '0;
      data_q   <= '0;
    end else begin
      we_q     <= accept_evt;
      reject_q <= refuse_evt;
      if (accept_evt) begin
        addr_q <= req_addr;
        data_q <= req_data;
      end
    end
  end

endmodule

// File: rtl/boot_vector_reg.sv
module boot_vector_reg #(
  parameter int               ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] RESET_VAL = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              held,
  input  logic              we,
  input  logic [ADDR_W-1:0] wdata,
  output logic              upd_evt,
  output logic [ADDR_W-1:0] value_q
);

  assign upd_evt = we & held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       value_q <= RESET_VAL;
    else if (upd_evt) value_q <= wdata;
  end

endmodule

// File: rtl/boot_hold_ctrl.sv
module boot_hold_ctrl #(
  parameter int               ADDR_W     = 16,
  parameter int               DATA_W     = 32,
  parameter logic [ADDR_W-1:0] BOOT_RESET = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dbg_frame_ok,
  input  logic              start,
  input  logic              dbg_wr_en,
  input  logic [ADDR_W-1:0] dbg_wr_addr,
  input  logic [DATA_W-1:0] dbg_wr_data,
  input  logic              dbg_boot_we,
  input  logic [ADDR_W-1:0] dbg_boot_addr,
  output logic              cpu_hold,
  output logic              tx_sel_dbg,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              wr_reject,
  output logic              pc_load,
  output logic [ADDR_W-1:0] pc_value
);

  // Named internal events, brought out for the checker.
  logic held;
  logic release_evt;
  logic wr_accept_evt;
  logic wr_refuse_evt;
  logic boot_upd_evt;

  boot_mode_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_ok   (dbg_frame_ok),
    .start      (start),
    .held       (held),
    .release_evt(release_evt),
    .pc_load_q  (pc_load)
  );

  tx_owner_latch u_tx (
    .clk     (clk),
    .rst_n   (rst_n),
    .frame_ok(dbg_frame_ok),
    .sel_dbg (tx_sel_dbg)
  );

  image_write_gate #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
    .clk       (clk),
    .rst_n     (rst_n),
    .held      (held),
    .req       (dbg_wr_en),
    .req_addr  (dbg_wr_addr),
    .req_data  (dbg_wr_data),
    .accept_evt(wr_accept_evt),
    .refuse_evt(wr_refuse_evt),
    .we_q      (mem_we),
    .addr_q    (mem_addr),
    .data_q    (mem_wdata),
    .reject_q  (wr_reject)
  );

  boot_vector_reg #(.ADDR_W(ADDR_W), .RESET_VAL(BOOT_RESET)) u_boot (
    .clk    (clk),
    .rst_n  (rst_n),
    .held   (held),
    .we     (dbg_boot_we),
    .wdata  (dbg_boot_addr),
    .upd_evt(boot_upd_evt),
    .value_q(pc_value)
  );

  assign cpu_hold = held;

endmodule

// File: rtl/boot_hold_ctrl_chk.sv
module boot_hold_ctrl_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dbg_frame_ok,
  input logic              start,
  input logic              dbg_wr_en,
  input logic [ADDR_W-1:0] dbg_wr_addr,
  input logic [DATA_W-1:0] dbg_wr_data,
  input logic              cpu_hold,
  input logic              tx_sel_dbg,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              wr_reject,
  input logic              pc_load,
  input logic              release_evt
);

  assert_frame_moves_tx_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_frame_ok |=> tx_sel_dbg);

  assert_tx_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_sel_dbg |=> tx_sel_dbg);

  assert_held_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_wr_en && cpu_hold) |=> (mem_we && !wr_reject &&
      mem_addr == $past(dbg_wr_addr) && mem_wdata == $past(dbg_wr_data)));

  assert_run_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dbg_wr_en && !cpu_hold) |=> (wr_reject && !mem_we));

  assert_no_spurious_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !dbg_wr_en |=> (!mem_we && !wr_reject));

  assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    release_evt |=> (!cpu_hold && pc_load));

  assert_pcload_only_at_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> $fell(cpu_hold));

  assert_run_stays_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_hold |=> (!cpu_hold && !pc_load));

  assert_release_needs_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_hold && !start) |=> cpu_hold);

endmodule

bind boot_hold_ctrl boot_hold_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .dbg_frame_ok(dbg_frame_ok),
  .start       (start),
  .dbg_wr_en   (dbg_wr_en),
  .dbg_wr_addr (dbg_wr_addr),
  .dbg_wr_data (dbg_wr_data),
  .cpu_hold    (cpu_hold),
  .tx_sel_dbg  (tx_sel_dbg),
  .mem_we      (mem_we),
  .mem_addr    (mem_addr),
  .mem_wdata   (mem_wdata),
  .wr_reject   (wr_reject),
  .pc_load     (pc_load),
  .release_evt (release_evt)
);

// File: tb/tb_boot_hold_ctrl.sv
module tb_boot_hold_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam logic [AW-1:0] BOOT_RST = 16'h0100;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          dbg_frame_ok = 1'b0, start = 1'b0, dbg_wr_en = 1'b0, dbg_boot_we = 1'b0;
  logic [AW-1:0] dbg_wr_addr = '0, dbg_boot_addr = '0;
  logic [DW-1:0] dbg_wr_data = '0;
  logic          cpu_hold, tx_sel_dbg, mem_we, wr_reject, pc_load;
  logic [AW-1:0] mem_addr, pc_value;
  logic [DW-1:0] mem_wdata;

  int n_checks = 0;
  int n_fails  = 0;

  // Reference model state
  logic          m_hold, m_tx;
  logic [AW-1:0] m_boot, m_addr;
  logic [DW-1:0] m_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  boot_hold_ctrl #(.ADDR_W(AW), .DATA_W(DW), .BOOT_RESET(BOOT_RST)) dut (
    .clk(clk), .rst_n(rst_n), .dbg_frame_ok(dbg_frame_ok), .start(start),
    .dbg_wr_en(dbg_wr_en), .dbg_wr_addr(dbg_wr_addr), .dbg_wr_data(dbg_wr_data),
    .dbg_boot_we(dbg_boot_we), .dbg_boot_addr(dbg_boot_addr),
    .cpu_hold(cpu_hold), .tx_sel_dbg(tx_sel_dbg), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .wr_reject(wr_reject),
    .pc_load(pc_load), .pc_value(pc_value)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic finish_test();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  // Expected outcomes, written from the requirements.
  function automatic logic exp_accept(input logic hold, input logic wr);
    return hold && wr;
  endfunction
  function automatic logic exp_refuse(input logic hold, input logic wr);
    return !hold && wr;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    dbg_frame_ok = 0; start = 0; dbg_wr_en = 0; dbg_boot_we = 0;
    @(posedge clk); #1;
    chk("R1", "hold in reset", 32'(cpu_hold), 32'd1);
    chk("R1", "tx in reset", 32'(tx_sel_dbg), 32'd0);
    chk("R1", "we/reject/pcload in reset", {29'd0, mem_we, wr_reject, pc_load}, 32'd0);
    chk("R1", "pc_value in reset", 32'(pc_value), 32'(BOOT_RST));
    @(negedge clk);
    rst_n = 1'b1;
    m_hold = 1; m_tx = 0; m_boot = BOOT_RST; m_addr = '0; m_data = '0;
  endtask

  // One clock: drive at negedge, check one edge later against the model.
  task automatic cyc(input string req, input logic fr, input logic st,
                     input logic wr, input logic [AW-1:0] wa, input logic [DW-1:0] wd,
                     input logic bw, input logic [AW-1:0] ba);
    logic e_we, e_rej, e_pcl;
    @(negedge clk);
    dbg_frame_ok = fr; start = st; dbg_wr_en = wr; dbg_wr_addr = wa;
    dbg_wr_data = wd; dbg_boot_we = bw; dbg_boot_addr = ba;
    e_we  = exp_accept(m_hold, wr);
    e_rej = exp_refuse(m_hold, wr);
    e_pcl = m_hold && st;
    if (e_we) begin m_addr = wa; m_data = wd; end
    if (bw && m_hold) m_boot = ba;
    if (fr) m_tx = 1'b1;
    if (st) m_hold = 1'b0;
    @(posedge clk); #1;
    chk(req, "cpu_hold", 32'(cpu_hold), 32'(m_hold));
    chk(req, "tx_sel_dbg", 32'(tx_sel_dbg), 32'(m_tx));
    chk(req, "mem_we", 32'(mem_we), 32'(e_we));
    chk(req, "wr_reject", 32'(wr_reject), 32'(e_rej));
    chk(req, "pc_load", 32'(pc_load), 32'(e_pcl));
    chk(req, "pc_value", 32'(pc_value), 32'(m_boot));
    if (e_we) begin
      chk(req, "mem_addr", 32'(mem_addr), 32'(m_addr));
      chk(req, "mem_wdata", mem_wdata, m_data);
    end
  endtask

  task automatic idle(input string req);
    cyc(req, 0, 0, 0, '0, '0, 0, '0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++; n_fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_test();
  end

  initial begin
    void'($urandom(32'd2024));
    do_reset();
    idle("R1");
    // R9: release directly from reset hold, no frame
    cyc("R9", 0, 1, 0, '0, '0, 0, '0);
    idle("R9");
    // R7: start while running ignored
    cyc("R7", 0, 1, 0, '0, '0, 0, '0);
    // R5: writes while running rejected, one per request
    cyc("R5", 0, 0, 1, 16'h0010, 32'hDEAD_BEEF, 0, '0);
    cyc("R5", 0, 0, 1, 16'h0011, 32'h1234_5678, 0, '0);
    // R8: boot write while running ignored
    cyc("R8", 0, 0, 0, '0, '0, 1, 16'hBEEF);
    // R2: frame in run still moves TX
    cyc("R2", 1, 0, 0, '0, '0, 0, '0);
    do_reset();
    // R2 / R3: frame in hold, then sticky
    cyc("R2", 1, 0, 0, '0, '0, 0, '0);
    idle("R3");
    // R4: held writes pass through
    cyc("R4", 0, 0, 1, 16'h0000, 32'hA5A5_0001, 0, '0);
    cyc("R4", 0, 0, 1, 16'hFFFF, 32'hFFFF_FFFF, 0, '0);
    // R8: boot write while held
    cyc("R8", 0, 0, 0, '0, '0, 1, 16'h2000);
    // R6 / R8: write, boot write and start in the same cycle
    cyc("R6", 0, 1, 1, 16'h0042, 32'h0000_0042, 1, 16'h3000);
    idle("R3");
    cyc("R3", 0, 1, 0, '0, '0, 0, '0);
    // R1: reset mid-run restores defaults
    do_reset();
    idle("R1");
    // Random phase
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 299) == 0) do_reset();
      cyc("R4/R5/R6 random",
          $urandom_range(0, 19) == 0,
          $urandom_range(0, 39) == 0,
          $urandom_range(0, 2) == 0,
          AW'($urandom), DW'($urandom),
          $urandom_range(0, 9) == 0,
          AW'($urandom));
    end
    finish_test();
  end

endmodule